// File: doc/BRIEF.md
# Text-Mode VGA Character Renderer

This block turns a grid of character cells into a raster video signal. Each cell holds a character code and a 3-bit colour. A free-running scan walks the frame one pixel per clock. For every visible pixel the block fetches the cell under the beam from an on-chip screen store, then fetches the matching glyph row from a computed font ROM. It overlays a blinking hardware cursor and drives active-low horizontal and vertical sync. The screen geometry, the porches, the glyph height and the font size are all parameters, fixed at elaboration.

A host updates the display through one write channel with valid/ready flow control. A transfer takes place on a clock edge where `wr_valid` and `wr_ready` are both high. Straight after reset the block fills every cell with its default content, and it holds `wr_ready` low until the fill is done. During that time the host must keep `wr_valid` and every write field steady. Once the fill has finished, `wr_ready` stays high and each write completes in a single cycle. `wr_cursor` selects the target of a write: the cursor register or a cell.

Top module: `vga_text_renderer`

## Requirements
- R1: The grid has COLS = H_ACTIVE/8 columns and ROWS = V_ACTIVE/GLYPH_H rows. Cell (c,r) covers pixels x in [8c, 8c+7] and lines y in [r·GLYPH_H, r·GLYPH_H+GLYPH_H-1].
- R2: `hsync_n` is low for H_SYNC pixels of every line, starting at x = H_ACTIVE+H_FP. `vsync_n` is low for V_SYNC whole lines, starting at y = V_ACTIVE+V_FP. Both are high during reset.
- R3: `rgb` is 3'b000 in every position outside the active area and during reset.
- R4: The scan starts at (0,0) when reset is released and advances one pixel per rising edge in raster order. The output for a position appears three clock cycles after the scan reaches it, so the first `hsync_n` low is seen H_ACTIVE+H_FP+3 edges after release.
- R5: Pixel x (0..7, left to right) on glyph line l of code c is lit when bit (7-x) of c XOR {l[3:0],l[3:0]} is 1. A lit pixel shows the cell colour (bit 2 red, bit 1 green, bit 0 blue). An unlit pixel is black.
- R6: After reset, cell index i = r·COLS+c holds code i mod NCHARS in green (3'b010). `wr_ready` is low from reset and rises after exactly COLS·ROWS rising edges.
- R7: An accepted write with `wr_cursor`=0 stores `wr_code` and `wr_color` into cell (`wr_col`,`wr_row`). The change is visible from the next frame on.
- R8: An accepted write with `wr_cursor`=1 moves the cursor to (`wr_col`,`wr_row`) and sets its style from `wr_style` (0 underline, 1 inverse). After reset the cursor is at (0,0) with underline style.
- R9: In underline style, every pixel of the last two glyph lines of the cursor cell is lit, while the cursor is visible.
- R10: In inverse style, every pixel of the cursor cell has its lit state inverted, while the cursor is visible.
- R11: The cursor is visible in frames where bit 4 of a frame count that starts at 0 on reset is 0. It is visible in frames 0..15 and hidden in frames 16..31.
- R12: A write whose column is ≥ COLS or whose row is ≥ ROWS changes no cell and leaves the cursor untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write channel can accept (low during fill) |
| wr_cursor | input | 1 | 1 = cursor write, 0 = cell write |
| wr_col | input | COL_W | Target column (one bit wider than needed) |
| wr_row | input | ROW_W | Target row (one bit wider than needed) |
| wr_code | input | CHAR_W | Character code for a cell write |
| wr_color | input | 3 | Cell colour {red, green, blue} |
| wr_style | input | 1 | Cursor style for a cursor write |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 3 | Pixel colour {red, green, blue} |

## Verification
The renderer is checked over whole frames against a raster model. The first frame holds the default fill, which checks the glyph formula and cell indexing on every cell at once. Single distinctive writes then go to the first and last cells, and a code of zero is written to isolate the line-pattern term. These writes show whether the address arithmetic, the bit order within a glyph row and the colour routing are right. The cursor is moved and restyled, and a frame captured after frame 16 tells the blink phase apart from the style logic. Out-of-grid writes are chosen so that a missing range check would alias onto a visible cell or hide the cursor.

// File: rtl/vga_text_pkg.sv
package vga_text_pkg;

  typedef enum logic {
    CUR_UNDERLINE = 1'b0,
    CUR_INVERSE   = 1'b1
  } cur_style_e;

  localparam logic [2:0] COLOR_GREEN = 3'b010;

  // Built-in glyph generator: one 8-pixel row of a character
  function automatic logic [7:0] glyph_bits(input logic [7:0] code,
                                            input logic [3:0] line);
    return code ^ {line, line};
  endfunction

endpackage

// File: rtl/vga_text_timing.sv
module vga_text_timing #(
  parameter int H_ACTIVE = 64,
  parameter int H_FP     = 4,
  parameter int H_SYNC   = 6,
  parameter int H_BP     = 4,
  parameter int V_ACTIVE = 36,
  parameter int V_FP     = 2,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 2,
  parameter int GLYPH_H  = 12,
  parameter int FRAME_W  = 5,
  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP,
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL),
  localparam int LW      = $clog2(GLYPH_H)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [HW-1:0]      hcnt,
  output logic [VW-1:0]      crow,
  output logic [LW-1:0]      gline,
  output logic               active,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic [FRAME_W-1:0] frame
);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [LW-1:0] G_LAST  = LW'(GLYPH_H - 1);
  localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACTIVE + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACTIVE + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACTIVE + V_FP + V_SYNC);

  logic [VW-1:0] vcnt;
  logic          line_end, frame_end;

  assign line_end  = (hcnt == H_LAST);
  assign frame_end = line_end && (vcnt == V_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      vcnt  <= '0;
      crow  <= '0;
      gline <= '0;
      frame <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (frame_end) begin
        vcnt  <= '0;
        crow  <= '0;
        gline <= '0;
        frame <= frame + 1'b1;
      end else if (line_end) begin
        vcnt <= vcnt + 1'b1;
        if (gline == G_LAST) begin
          gline <= '0;
          crow  <= crow + 1'b1;
        end else begin
          gline <= gline + 1'b1;
        end
      end
    end
  end

  assign active  = (hcnt < H_VIS) && (vcnt < V_VIS);
  assign hsync_n = !((hcnt >= HS_BEG) && (hcnt < HS_END));
  assign vsync_n = !((vcnt >= VS_BEG) && (vcnt < VS_END));

  // R4: scan position never leaves the frame
  p_hpos_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt <= H_LAST) && (vcnt <= V_LAST));

  // R2: vertical sync only changes at the start of a line
  p_vsync_on_line_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vsync_n) |-> (hcnt == '0));

  // R11: the frame count only moves when a frame ends
  p_frame_steps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(frame));

endmodule

// File: rtl/vga_text_screen.sv
module vga_text_screen
  import vga_text_pkg::*;
#(
  parameter int COLS   = 8,
  parameter int ROWS   = 3,
  parameter int CHAR_W = 7,
  localparam int CELLS = COLS * ROWS,
  localparam int AW    = $clog2(CELLS),
  localparam int COL_W = $clog2(COLS) + 1,
  localparam int ROW_W = $clog2(ROWS) + 1,
  localparam int DW    = CHAR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_cursor,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [CHAR_W-1:0] wr_code,
  input  logic [2:0]        wr_color,
  input  logic              wr_style,
  input  logic [AW-1:0]     rd_addr,
  output logic [CHAR_W-1:0] rd_code,
  output logic [2:0]        rd_color,
  output logic [COL_W-1:0]  cur_col,
  output logic [ROW_W-1:0]  cur_row,
  output cur_style_e        cur_style
);

  logic [DW-1:0] mem [CELLS];
  logic [DW-1:0] rd_q;
  logic          fill_busy;
  logic [AW-1:0] fill_idx;
  logic          in_grid, take;
  logic          we;
  logic [AW-1:0] waddr, host_addr;
  logic [DW-1:0] wdata;

  assign wr_ready  = !fill_busy;
  assign take      = wr_valid && wr_ready;
  assign in_grid   = (int'(wr_col) < COLS) && (int'(wr_row) < ROWS);
  assign host_addr = AW'(wr_row) * AW'(COLS) + AW'(wr_col);

  always_comb begin
    we    = 1'b0;
    waddr = host_addr;
    wdata = {wr_code, wr_color};
    if (fill_busy) begin
      we    = 1'b1;
      waddr = fill_idx;
      wdata = {CHAR_W'(fill_idx), COLOR_GREEN};
    end else if (take && !wr_cursor && in_grid) begin
      we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[rd_addr];
  end

  assign rd_code  = rd_q[DW-1:3];
  assign rd_color = rd_q[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_busy <= 1'b1;
      fill_idx  <= '0;
    end else if (fill_busy) begin
      if (fill_idx == AW'(CELLS - 1)) fill_busy <= 1'b0;
      else                            fill_idx  <= fill_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_col   <= '0;
      cur_row   <= '0;
      cur_style <= CUR_UNDERLINE;
    end else if (take && wr_cursor && in_grid) begin
      cur_col   <= wr_col;
      cur_row   <= wr_row;
      cur_style <= cur_style_e'(wr_style);
    end
  end

  // R6: once the fill is over it never restarts without reset
  p_fill_stays_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_busy |=> !fill_busy);

  // R12: an out-of-grid request leaves the cursor untouched
  p_oob_keeps_cursor_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !in_grid) |=> ($stable(cur_col) && $stable(cur_row) && $stable(cur_style)));

endmodule

// File: rtl/vga_text_font.sv
module vga_text_font
  import vga_text_pkg::*;
#(
  parameter int CHAR_W = 7,
  parameter int LW     = 4
) (
  input  logic              clk,
  input  logic [CHAR_W-1:0] code,
  input  logic [LW-1:0]     line,
  output logic [7:0]        bits
);

  always_ff @(posedge clk) begin
    bits <= glyph_bits(8'(code), 4'(line));
  end

endmodule

// File: rtl/vga_text_renderer.sv
module vga_text_renderer
  import vga_text_pkg::*;
#(
  parameter int H_ACTIVE = 64,
  parameter int H_FP     = 4,
  parameter int H_SYNC   = 6,
  parameter int H_BP     = 4,
  parameter int V_ACTIVE = 36,
  parameter int V_FP     = 2,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 2,
  parameter int GLYPH_H  = 12,
  parameter int NCHARS   = 128,
  localparam int COLS    = H_ACTIVE / 8,
  localparam int ROWS    = V_ACTIVE / GLYPH_H,
  localparam int CHAR_W  = $clog2(NCHARS),
  localparam int COL_W   = $clog2(COLS) + 1,
  localparam int ROW_W   = $clog2(ROWS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_cursor,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [CHAR_W-1:0] wr_code,
  input  logic [2:0]        wr_color,
  input  logic              wr_style,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic [2:0]        rgb
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int LW      = $clog2(GLYPH_H);
  localparam int AW      = $clog2(COLS * ROWS);
  localparam int FRAME_W = 5;
  localparam logic [LW-1:0] UL_FIRST = LW'(GLYPH_H - 2);

  // stage 0: scan position
  logic [HW-1:0]      hcnt;
  logic [VW-1:0]      crow;
  logic [LW-1:0]      gline;
  logic               active, hs0, vs0;
  logic [FRAME_W-1:0] frame;
  logic [AW-1:0]      rd_addr;
  logic               hit0;
  logic [COL_W-1:0]   cur_col;
  logic [ROW_W-1:0]   cur_row;
  cur_style_e         cur_style;

  vga_text_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .GLYPH_H(GLYPH_H), .FRAME_W(FRAME_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .crow(crow), .gline(gline),
    .active(active), .hsync_n(hs0), .vsync_n(vs0), .frame(frame)
  );

  assign rd_addr = active ? AW'(crow) * AW'(COLS) + AW'(hcnt[HW-1:3]) : '0;
  assign hit0    = (int'(hcnt[HW-1:3]) == int'(cur_col)) && (int'(crow) == int'(cur_row));

  // stage 1: cell read in flight
  logic [CHAR_W-1:0] cell_code;
  logic [2:0]        cell_color;
  logic [2:0]        s1_x, s2_x;
  logic [LW-1:0]     s1_line, s2_line;
  logic              s1_blank, s2_blank, s1_hs, s2_hs, s1_vs, s2_vs, s1_hit, s2_hit;
  logic [2:0]        s2_color;
  logic [7:0]        glyph;

  vga_text_screen #(.COLS(COLS), .ROWS(ROWS), .CHAR_W(CHAR_W)) u_screen (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_cursor(wr_cursor),
    .wr_col(wr_col), .wr_row(wr_row), .wr_code(wr_code), .wr_color(wr_color),
    .wr_style(wr_style), .rd_addr(rd_addr), .rd_code(cell_code), .rd_color(cell_color),
    .cur_col(cur_col), .cur_row(cur_row), .cur_style(cur_style)
  );

  vga_text_font #(.CHAR_W(CHAR_W), .LW(LW)) u_font (
    .clk(clk), .code(cell_code), .line(s1_line), .bits(glyph)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_x <= '0; s1_line <= '0; s1_blank <= 1'b1; s1_hs <= 1'b1; s1_vs <= 1'b1; s1_hit <= 1'b0;
      s2_x <= '0; s2_line <= '0; s2_blank <= 1'b1; s2_hs <= 1'b1; s2_vs <= 1'b1; s2_hit <= 1'b0;
      s2_color <= '0;
    end else begin
      s1_x     <= hcnt[2:0];
      s1_line  <= gline;
      s1_blank <= !active;
      s1_hs    <= hs0;
      s1_vs    <= vs0;
      s1_hit   <= hit0;
      s2_x     <= s1_x;
      s2_line  <= s1_line;
      s2_blank <= s1_blank;
      s2_hs    <= s1_hs;
      s2_vs    <= s1_vs;
      s2_hit   <= s1_hit;
      s2_color <= cell_color;
    end
  end

  // stage 3: pixel select, cursor overlay, output registers
  logic glyph_on, cursor_shown, pix_on;

  always_comb begin
    glyph_on     = glyph[3'd7 - s2_x];
    cursor_shown = s2_hit && !frame[4];
    pix_on       = glyph_on;
    if (cursor_shown) begin
      if (cur_style == CUR_INVERSE)  pix_on = !glyph_on;
      else if (s2_line >= UL_FIRST)  pix_on = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb     <= 3'b000;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      rgb     <= (!s2_blank && pix_on) ? s2_color : 3'b000;
      hsync_n <= s2_hs;
      vsync_n <= s2_vs;
    end
  end

  // R3: a blanked position always reaches the pins as black
  p_blank_is_black_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s2_blank |=> (rgb == 3'b000));

  // R4: the sync pins follow the delayed scan sync one cycle later
  p_sync_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hsync_n == $past(s2_hs)) && (vsync_n == $past(s2_vs)));

endmodule

// File: tb/vga_text_renderer_test.sv
module vga_text_renderer_test;

  localparam int HA = 64, HFP = 4, HSW = 6, HBP = 4;
  localparam int VA = 36, VFP = 2, VSW = 2, VBP = 2;
  localparam int GH = 12, NCH = 128;
  localparam int HT = HA + HFP + HSW + HBP;
  localparam int VT = VA + VFP + VSW + VBP;
  localparam int NCOL = HA / 8, NROW = VA / GH, NCELL = NCOL * NROW;
  localparam int FRAME_CYC = HT * VT;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0, wr_cursor = 1'b0, wr_style = 1'b0;
  logic [3:0] wr_col = '0;
  logic [2:0] wr_row = '0;
  logic [6:0] wr_code = '0;
  logic [2:0] wr_color = '0;
  logic       wr_ready, hsync_n, vsync_n;
  logic [2:0] rgb;

  always #4 clk = ~clk;

  vga_text_renderer #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSW), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSW), .V_BP(VBP),
    .GLYPH_H(GH), .NCHARS(NCH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_cursor(wr_cursor), .wr_col(wr_col), .wr_row(wr_row), .wr_code(wr_code),
    .wr_color(wr_color), .wr_style(wr_style),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .rgb(rgb)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // raster model state
  int mcode [NCELL];
  int mcolor[NCELL];
  int ccol = 0, crow_m = 0, cstyle = 0;
  int bh = 0, bv = 0, bf = 0;
  int d1h, d1v, d1f, d2h, d2v, d2f, d3h, d3v, d3f;

  function automatic void expect_at(input int h, input int v, input int f,
                                    output int e_rgb, output int e_hs, output int e_vs);
    int col, row, line, x, idx, bits, on;
    e_hs  = (h >= HA + HFP && h < HA + HFP + HSW) ? 0 : 1;
    e_vs  = (v >= VA + VFP && v < VA + VFP + VSW) ? 0 : 1;
    e_rgb = 0;
    if (h < HA && v < VA) begin
      col  = h / 8;  row = v / GH;  line = v % GH;  x = h % 8;
      idx  = row * NCOL + col;
      bits = (mcode[idx] ^ ((line << 4) | line)) & 255;
      on   = (bits >> (7 - x)) & 1;
      if (col == ccol && row == crow_m && ((f >> 4) & 1) == 0) begin
        if (cstyle == 1)         on = 1 - on;
        else if (line >= GH - 2) on = 1;
      end
      e_rgb = (on != 0) ? mcolor[idx] : 0;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bh <= 0; bv <= 0; bf <= 0;
      d1h <= 0; d1v <= 0; d1f <= 0; d2h <= 0; d2v <= 0; d2f <= 0;
      d3h <= 0; d3v <= 0; d3f <= 0;
    end else begin
      d3h <= d2h; d3v <= d2v; d3f <= d2f;
      d2h <= d1h; d2v <= d1v; d2f <= d1f;
      d1h <= bh;  d1v <= bv;  d1f <= bf;
      if (bh == HT - 1) begin
        bh <= 0;
        if (bv == VT - 1) begin bv <= 0; bf <= bf + 1; end
        else bv <= bv + 1;
      end else bh <= bh + 1;
    end
  end

  bit cmp_en = 1'b0;
  int pix_err = 0, blank_err = 0, sync_err = 0;
  int first_act = 0, first_exp = 0, e_rgb, e_hs, e_vs;

  always @(negedge clk) begin
    if (cmp_en) begin
      expect_at(d3h, d3v, d3f, e_rgb, e_hs, e_vs);
      if (int'(rgb) != e_rgb) begin
        if (pix_err + blank_err == 0) begin first_act = int'(rgb); first_exp = e_rgb; end
        if (d3h < HA && d3v < VA) pix_err++;
        else blank_err++;
      end
      if (int'(hsync_n) != e_hs || int'(vsync_n) != e_vs) sync_err++;
    end
  end

  task automatic check_frame(input string req);
    @(posedge clk);
    pix_err = 0; blank_err = 0; sync_err = 0;
    cmp_en = 1'b1;
    repeat (FRAME_CYC) @(posedge clk);
    cmp_en = 1'b0;
    check(pix_err == 0, req, first_act, first_exp, "active pixels vs raster model");
    check(blank_err == 0, "R3", blank_err, 0, "non-black pixels in blanking");
    check(sync_err == 0, "R2", sync_err, 0, "sync mismatches in frame");
  endtask

  task automatic host_write(input bit cur, input int col, input int row, input int code,
                            input int color, input bit style);
    @(negedge clk);
    wr_valid = 1'b1; wr_cursor = cur; wr_col = 4'(col); wr_row = 3'(row);
    wr_code = 7'(code); wr_color = 3'(color); wr_style = style;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    if (col < NCOL && row < NROW) begin
      if (cur) begin ccol = col; crow_m = row; cstyle = int'(style); end
      else begin mcode[row * NCOL + col] = code; mcolor[row * NCOL + col] = color; end
    end
    repeat (4) @(posedge clk);
  endtask

  typedef struct packed {
    logic       cur;
    logic [3:0] col;
    logic [2:0] row;
    logic [6:0] code;
    logic [2:0] color;
    logic       style;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'd1, 3'd0, 7'h41, 3'b100, 1'b0, 4'd7},   // R7 cell store in red
    '{1'b0, 4'd7, 3'd2, 7'h7F, 3'b111, 1'b0, 4'd1},   // R1 last cell placement
    '{1'b0, 4'd0, 3'd1, 7'h00, 3'b001, 1'b0, 4'd5},   // R5 line pattern only
    '{1'b1, 4'd2, 3'd1, 7'h00, 3'b000, 1'b1, 4'd10},  // R10 inverse cursor (R8 move)
    '{1'b1, 4'd5, 3'd2, 7'h00, 3'b000, 1'b0, 4'd9},   // R9 underline cursor (R8 move)
    '{1'b0, 4'd5, 3'd2, 7'h10, 3'b011, 1'b0, 4'd9},   // R9 under cursor cell
    '{1'b0, 4'd8, 3'd0, 7'h33, 3'b110, 1'b0, 4'd12},  // R12 column out of grid
    '{1'b0, 4'd0, 3'd3, 7'h55, 3'b101, 1'b0, 4'd12},  // R12 row out of grid
    '{1'b1, 4'd9, 3'd1, 7'h00, 3'b000, 1'b1, 4'd12}   // R12 cursor out of grid
  };

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < NCELL; i++) begin mcode[i] = i % NCH; mcolor[i] = 2; end

    // reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rgb == 3'b000, "R3", int'(rgb), 0, "rgb in reset");
    check(hsync_n == 1'b1, "R2", int'(hsync_n), 1, "hsync_n in reset");
    check(vsync_n == 1'b1, "R2", int'(vsync_n), 1, "vsync_n in reset");
    check(wr_ready == 1'b0, "R6", int'(wr_ready), 0, "wr_ready in reset");
    rst_n = 1'b1;

    // fill length and first sync edge, counted in edges from release
    begin
      int ready_at = -1, hs_at = -1;
      for (int n = 1; n <= 100; n++) begin
        @(posedge clk);
        @(negedge clk);
        if (ready_at < 0 && wr_ready) ready_at = n;
        if (hs_at < 0 && !hsync_n) hs_at = n;
      end
      check(ready_at == NCELL, "R6", ready_at, NCELL, "edges until wr_ready");
      check(hs_at == HA + HFP + 3, "R4", hs_at, HA + HFP + 3, "edges until first hsync low");
    end

    // default content with reset cursor
    check_frame("R6");

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      host_write(VECS[k].cur, int'(VECS[k].col), int'(VECS[k].row), int'(VECS[k].code),
                 int'(VECS[k].color), VECS[k].style);
      check(wr_ready == 1'b1, "R8", int'(wr_ready), 1, "ready after write");
      check_frame($sformatf("R%0d", VECS[k].req));
    end

    // blink: frame 16 shows no cursor
    check(bf < 16, "R11", bf, 15, "still inside visible blink phase");
    while (bf != 16) @(posedge clk);
    check_frame("R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule